// File: doc/BRIEF.md
# Real-Time Clock Seconds Prescaler

This block turns a crystal clock into the one-second tick that drives the calendar counters of a real-time clock. It has two ways of dividing. With the compare-mode bit clear it divides by a fixed 32768, which suits a standard watch crystal. With the bit set it counts up to a terminal value held in a compare register. Software loads that register with the crystal rate minus one, so crystals between 32000 Hz and 2^22 Hz can be used.

Software reaches the block through a simple 32-bit register bus on the bus clock. The control register holds the enable bit, a read-only enable-status bit, the compare-mode bit and a 24-hour-format bit. The status bit is the enable bit after it has crossed into the crystal domain and been read back, so it confirms a change only after a short delay. The mode bits and the compare value are locked while the counter runs. The intended sequence is to disable the counter, wait for the status bit to read 0, set the mode and compare value, and then enable the counter with a separate write.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the compare register (offset 0x3C) reads 32767, and tick_o stays low.
- R2: Control register fields: bit 7 is enable, bit 6 is status (read-only; writes have no effect), bit 5 is 24-hour format, bit 4 is compare mode. All other bits read 0. Bits 5 and 4 also appear on fmt24_o and cmp_mode_o.
- R3: After a write that sets enable, status reads 1 no sooner than one crystal period and no later than four crystal periods after the write takes effect.
- R4: After a write that clears enable, status returns to 0 within the same window as in R3.
- R5: With compare mode clear, consecutive ticks are exactly 32768 crystal cycles apart.
- R6: With compare mode set, consecutive ticks are exactly compare+1 crystal cycles apart. Each tick lasts one crystal cycle.
- R7: While the counter is disabled its count is held at zero. After re-enabling, the first tick arrives compare+1 crystal cycles after the crystal domain sees the enable, whatever the count was when the counter was disabled.
- R8: A write to the compare register is ignored while the enable bit or the status bit reads 1.
- R9: While the enable bit or the status bit reads 1, a control write changes only the enable bit. The format and mode bits keep their values.
- R10: The compare register is 22 bits wide. Writing 0xFFFFFFFF reads back as 0x003FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| xtal_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| sel_i | input | 1 | Bus access select |
| we_i | input | 1 | Write strobe, qualified by sel_i |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, available in the same cycle |
| tick_o | output | 1 | One-second tick, one crystal cycle wide, in the crystal domain |
| en_status_o | output | 1 | Status bit: enable as seen after crossing into the crystal domain |
| fmt24_o | output | 1 | 24-hour format bit |
| cmp_mode_o | output | 1 | Compare-prescaler mode bit |

## Verification
The hardest case to reach is a counter disabled partway through a period and then re-enabled, since a leftover count only shows up as a shortened first period. The stimulus loads a small compare value and enables the counter. It disables the counter roughly halfway to the next tick and waits for status to read 0. It then enables again and measures the crystal cycles from the status rising edge to the first tick. The status delay is also measured in nanoseconds across the two asynchronous clocks, whose periods are chosen to be unequal so that the phase between them shifts.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;
  localparam logic [7:0] CTL_OFS   = 8'h00;
  localparam logic [7:0] CMP_OFS   = 8'h3C;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned STAT_BIT = 6;
  localparam int unsigned FMT_BIT  = 5;
  localparam int unsigned MODE_BIT = 4;
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == term_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= term_i);
  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  // R6
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && term_i != '0) |=> !tick_o);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pre_pkg::*;
#(
  parameter int unsigned FIXED_DIV = 32768,
  parameter int unsigned CMP_W     = 22,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic        clk_i,
  input  logic        xtal_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        tick_o,
  output logic        en_status_o,
  output logic        fmt24_o,
  output logic        cmp_mode_o
);
  localparam logic [CMP_W-1:0] FIX_TERM = CMP_W'(FIXED_DIV - 1);

  logic             en_q, fmt_q, mode_q, status_q, en_x, lock;
  logic [CMP_W-1:0] cmp_q, term;
  logic             wr_ctl, wr_cmp;

  assign wr_ctl = sel_i && we_i && (addr_i == CTL_OFS);
  assign wr_cmp = sel_i && we_i && (addr_i == CMP_OFS);
  assign lock   = en_q | status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      fmt_q  <= 1'b0;
      mode_q <= 1'b0;
      cmp_q  <= FIX_TERM;
    end else begin
      if (wr_ctl) begin
        en_q <= wdata_i[EN_BIT];
        if (!lock) begin
          fmt_q  <= wdata_i[FMT_BIT];
          mode_q <= wdata_i[MODE_BIT];
        end
      end
      if (wr_cmp && !lock) cmp_q <= wdata_i[CMP_W-1:0];
    end
  end

  // enable into crystal domain, then read back on bus clock
  rtc_sync2 #(.STAGES(SYNC_N)) u_en_sync (
    .clk_i (xtal_i),
    .rst_ni(rst_ni),
    .d_i   (en_q),
    .q_o   (en_x)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= en_x;

  assign term = mode_q ? cmp_q : FIX_TERM;

  rtc_divider #(.CNT_W(CMP_W)) u_div (
    .clk_i (xtal_i),
    .rst_ni(rst_ni),
    .en_i  (en_x),
    .term_i(term),
    .tick_o(tick_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      CTL_OFS: begin
        rdata_o[EN_BIT]   = en_q;
        rdata_o[STAT_BIT] = status_q;
        rdata_o[FMT_BIT]  = fmt_q;
        rdata_o[MODE_BIT] = mode_q;
      end
      CMP_OFS: rdata_o[CMP_W-1:0] = cmp_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_status_o = status_q;
  assign fmt24_o     = fmt_q;
  assign cmp_mode_o  = mode_q;

  // R8
  lock_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> $stable(cmp_q));
  // R9
  lock_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> ($stable(mode_q) && $stable(fmt_q)));
endmodule

// File: tb/rtc_prescaler_tb.sv
module rtc_prescaler_tb;
  logic        clk = 0, xtal = 0, rst_n = 0;
  logic        sel = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        tick, stat, fmt24, cmode;
  int          n_chk = 0, n_bad = 0;
  longint      xcnt = 0;

  always #4 clk = ~clk;
  always #5 xtal = ~xtal;
  always @(posedge xtal) xcnt <= xcnt + 1;

  rtc_prescaler u_dut (
    .clk_i(clk), .xtal_i(xtal), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick),
    .en_status_o(stat), .fmt24_o(fmt24), .cmp_mode_o(cmode)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; sel = 1;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic wait_stat(input logic v);
    while (stat !== v) @(negedge clk);
  endtask

  task automatic wait_tick(output longint at);
    @(negedge xtal);
    while (tick !== 1'b1) @(negedge xtal);
    at = xcnt;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(8'h00, d); check("R1 ctl", d, 0);
    bus_rd(8'h3C, d); check("R1 cmp", d, 32767);
    repeat (50) begin
      @(negedge xtal);
      if (tick) break;
    end
    check("R1 tick", tick, 0);
  endtask

  task automatic t_ctl_bits;
    logic [31:0] d;
    bus_wr(8'h00, 32'hFFFF_FF70);
    bus_rd(8'h00, d); check("R2 bits", d, 32'h30);
    check("R2 fmt24_o", fmt24, 1);
    check("R2 cmp_mode_o", cmode, 1);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h00, d); check("R2 clear", d, 0);
  endtask

  task automatic t_cmp_width;
    logic [31:0] d;
    bus_wr(8'h3C, 32'hFFFF_FFFF);
    bus_rd(8'h3C, d); check("R10 width", d, 32'h003F_FFFF);
  endtask

  task automatic t_status_timing;
    realtime t0, dt;
    bus_wr(8'h3C, 32'd9);
    @(negedge clk); sel = 1; we = 1; addr = 8'h00; wdata = 32'h90;
    @(posedge clk); t0 = $realtime;
    @(negedge clk); sel = 0; we = 0;
    while (stat !== 1'b1) @(posedge clk);
    dt = $realtime - t0;
    check_rng("R3 rise ns", longint'(dt), 11, 40);
    @(negedge clk); sel = 1; we = 1; addr = 8'h00; wdata = 32'h10;
    @(posedge clk); t0 = $realtime;
    @(negedge clk); sel = 0; we = 0;
    while (stat !== 1'b0) @(posedge clk);
    dt = $realtime - t0;
    check_rng("R4 fall ns", longint'(dt), 11, 40);
  endtask

  task automatic t_cmp_mode;
    longint a, b, c;
    bus_wr(8'h3C, 32'd9);
    bus_wr(8'h00, 32'h90);
    wait_tick(a); wait_tick(b); wait_tick(c);
    check("R6 period1", b - a, 10);
    check("R6 period2", c - b, 10);
    @(negedge xtal); check("R6 pulse width", tick, 0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    bus_wr(8'h3C, 32'd5);
    bus_rd(8'h3C, d); check("R8 cmp locked", d, 9);
    bus_wr(8'h00, 32'hA0);
    bus_rd(8'h00, d); check("R9 mode kept", d & 32'hB0, 32'h90);
    bus_wr(8'h00, 32'h00);
    bus_rd(8'h00, d); check("R9 enable writable", d[7], 0);
    wait_stat(0);
  endtask

  task automatic t_hold_zero;
    longint s, t;
    bus_wr(8'h3C, 32'd99);
    bus_wr(8'h00, 32'h90);
    wait_stat(1);
    repeat (50) @(negedge xtal);
    bus_wr(8'h00, 32'h10);
    wait_stat(0);
    repeat (5) @(negedge xtal);
    bus_wr(8'h00, 32'h90);
    @(negedge xtal);
    while (stat !== 1'b1) @(negedge xtal);
    s = xcnt;
    wait_tick(t);
    check_rng("R7 first tick", t - s, 99, 100);
    bus_wr(8'h00, 32'h10);
    wait_stat(0);
  endtask

  task automatic t_fixed;
    longint a, b;
    bus_wr(8'h00, 32'h00);
    bus_wr(8'h00, 32'h80);
    wait_tick(a); wait_tick(b);
    check("R5 fixed period", b - a, 32768);
    bus_wr(8'h00, 32'h00);
    wait_stat(0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctl_bits();
    t_cmp_width();
    t_status_timing();
    t_cmp_mode();
    t_lock();
    t_hold_zero();
    t_fixed();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule